// File: doc/BRIEF.md
# Seven-to-One Parallel Video Serializer

The block takes a 28-bit parallel pixel word once per pixel clock and sends it out over four serial data lanes and one framing clock lane. Each lane carries a 7-bit slice of the word per pixel period, so the lanes shift on a bit clock that runs at seven times the pixel rate. The user selects whether a word is captured on the rising or the falling edge of the pixel clock. The bench, or the clock generator, marks the slot that starts each frame with a strobe that is phase-aligned to the bit clock.

The clock lane sends four ones followed by three zeros in every frame, in step with the data slices. A receiver locks onto the zero-to-one step of this lane to find slot 0. The PLL that makes the bit clock is outside the block and is seen only through its lock indication. The lanes carry data only once lock is seen. An active-low power-down input clears every register at once and keeps all outputs low.

Top module: `vs7_serializer`

## Requirements
- R1: Lane l (l = 0..3) carries word bits 7l+6 down to 7l, so lane 0 takes bits 6..0 and lane 3 takes bits 27..21.
- R2: In slot s (s = 0..6) of a frame, lane l sends word bit 7l+6-s. The most significant bit of the slice goes first and the least significant bit goes last.
- R3: With `edge_rise` = 1 the word on `pix_data` is captured at the rising edge of `clk_pix`. With `edge_rise` = 0 it is captured at the falling edge.
- R4: While `lanes_en` is 1, `clk_lane` sends 1,1,1,1,0,0,0 in slots 0..6 of each frame.
- R5: A `clk_bit` rising edge that samples `frame_start` = 1 loads the word most recently captured. Slot 0 is driven in the `clk_bit` cycle that follows that edge, and each later slot follows one `clk_bit` cycle after the one before.
- R6: While `pwr_n` is 0, all registers are cleared asynchronously and `lane_bit`, `clk_lane` and `lanes_en` are 0.
- R7: `lanes_en` rises only at an edge that loads a frame, and only after `pll_locked` has passed a two-stage synchronizer. It falls within three `clk_bit` edges after lock is lost. While `lanes_en` is 0, `lane_bit` and `clk_lane` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Pixel clock on which the parallel word is presented |
| clk_bit | input | 1 | Bit clock at seven times the pixel rate |
| frame_start | input | 1 | High in the bit-clock cycle whose ending edge starts a frame |
| pll_locked | input | 1 | Lock indication of the bit-clock generator |
| edge_rise | input | 1 | 1 = capture on the rising pixel edge, 0 = capture on the falling pixel edge |
| pwr_n | input | 1 | Active-low power-down and clear |
| pix_data | input | 28 | Parallel pixel word |
| lane_bit | output | 4 | Serial data bit of each lane |
| clk_lane | output | 1 | Serial framing clock lane bit |
| lanes_en | output | 1 | Lanes carry valid data |

## Verification
The bench builds the block with its default parameters: four lanes of seven slots, a clock lane high for four slots, a two-stage lock synchronizer, dual-edge capture and most-significant-bit-first shifting. These values make both capture registers and the output multiplexer reachable. Each period presents one word before the rising edge and a different word before the falling edge, so the selected edge decides which word must come back. A receiver model aligned on the clock lane rebuilds every word and checks the slot timing across power-down and lock-loss events.

// File: rtl/vs7_pkg.sv
`timescale 1ns/1ps
package vs7_pkg;
   localparam int unsigned MAX_SLICE = 32;

   // Framing pattern, MSB-first: the top `hi` of `n` slots are high.
   function automatic logic [MAX_SLICE-1:0] clk_pattern(int unsigned n, int unsigned hi);
      logic [MAX_SLICE-1:0] p;
      p = '0;
      for (int unsigned i = 0; i < MAX_SLICE; i++)
         if (i < n && i + hi >= n) p[i] = 1'b1;
      return p;
   endfunction
endpackage

// File: rtl/vs7_capture.sv
`timescale 1ns/1ps
module vs7_capture #(
   parameter int unsigned WIDTH       = 28,
   parameter bit          EDGE_SEL_EN = 1'b1
) (
   input  logic             clk_pix,
   input  logic             rst_n,
   input  logic             edge_rise,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] word_o
);
   logic [WIDTH-1:0] rise_q;

   always_ff @(posedge clk_pix or negedge rst_n) begin
      if (!rst_n) rise_q <= '0;
      else        rise_q <= din;
   end

   generate
      if (EDGE_SEL_EN) begin : g_dual
         logic [WIDTH-1:0] fall_q;
         always_ff @(negedge clk_pix or negedge rst_n) begin
            if (!rst_n) fall_q <= '0;
            else        fall_q <= din;
         end
         assign word_o = edge_rise ? rise_q : fall_q;
      end else begin : g_rise
         assign word_o = rise_q;
      end
   endgenerate
endmodule

// File: rtl/vs7_lane_shift.sv
`timescale 1ns/1ps
module vs7_lane_shift #(
   parameter int unsigned SLICE     = 7,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SLICE-1:0] slice_i,
   output logic             ser_o
);
   logic [SLICE-1:0] sh_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sh_q <= '0;
            else if (load) sh_q <= slice_i;
            else           sh_q <= {sh_q[SLICE-2:0], 1'b0};
         end
         assign ser_o = sh_q[SLICE-1];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sh_q <= '0;
            else if (load) sh_q <= slice_i;
            else           sh_q <= {1'b0, sh_q[SLICE-1:1]};
         end
         assign ser_o = sh_q[0];
      end
   endgenerate
endmodule

// File: rtl/vs7_frame_ctl.sv
`timescale 1ns/1ps
module vs7_frame_ctl #(
   parameter int unsigned SLICE       = 7,
   parameter int unsigned CLK_HIGH    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_bit,
   input  logic rst_n,
   input  logic frame_start,
   input  logic pll_locked,
   output logic load_o,
   output logic en_o,
   output logic pat_o
);
   localparam logic [SLICE-1:0] PATTERN = SLICE'(vs7_pkg::clk_pattern(SLICE, CLK_HIGH));

   logic [SYNC_STAGES-1:0] lock_sync;
   logic                   lock_ok;
   logic                   en_q;
   logic                   pat_ser;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk_bit or negedge rst_n) begin
            if (!rst_n) lock_sync <= '0;
            else        lock_sync <= pll_locked;
         end
      end else begin : g_syncn
         always_ff @(posedge clk_bit or negedge rst_n) begin
            if (!rst_n) lock_sync <= '0;
            else        lock_sync <= {lock_sync[SYNC_STAGES-2:0], pll_locked};
         end
      end
   endgenerate

   assign lock_ok = lock_sync[SYNC_STAGES-1];

   // Enable opens only on a frame boundary, closes as soon as lock is gone.
   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)           en_q <= 1'b0;
      else if (!lock_ok)    en_q <= 1'b0;
      else if (frame_start) en_q <= 1'b1;
   end

   vs7_lane_shift #(.SLICE(SLICE), .MSB_FIRST(1'b1)) pat_sh_i (
      .clk     (clk_bit),
      .rst_n   (rst_n),
      .load    (frame_start),
      .slice_i (PATTERN),
      .ser_o   (pat_ser)
   );

   assign load_o = frame_start;
   assign en_o   = en_q;
   assign pat_o  = pat_ser & en_q;
endmodule

// File: rtl/vs7_serializer.sv
`timescale 1ns/1ps
module vs7_serializer #(
   parameter int unsigned LANES       = 4,
   parameter int unsigned SLICE       = 7,
   parameter int unsigned CLK_HIGH    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EDGE_SEL_EN = 1'b1,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic                   clk_pix,
   input  logic                   clk_bit,
   input  logic                   frame_start,
   input  logic                   pll_locked,
   input  logic                   edge_rise,
   input  logic                   pwr_n,
   input  logic [LANES*SLICE-1:0] pix_data,
   output logic [LANES-1:0]       lane_bit,
   output logic                   clk_lane,
   output logic                   lanes_en
);
   localparam int unsigned WORD = LANES * SLICE;

   generate
      if (SLICE < 2 || SLICE > vs7_pkg::MAX_SLICE) begin : g_bad_slice
         $error("vs7_serializer: SLICE out of range");
      end
      if (CLK_HIGH < 1 || CLK_HIGH >= SLICE) begin : g_bad_high
         $error("vs7_serializer: CLK_HIGH must lie in 1..SLICE-1");
      end
      if (LANES < 1 || SYNC_STAGES < 1) begin : g_bad_count
         $error("vs7_serializer: LANES and SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [WORD-1:0]  word;
   logic [LANES-1:0] ser;
   logic             load;
   logic             en;

   vs7_capture #(.WIDTH(WORD), .EDGE_SEL_EN(EDGE_SEL_EN)) cap_i (
      .clk_pix   (clk_pix),
      .rst_n     (pwr_n),
      .edge_rise (edge_rise),
      .din       (pix_data),
      .word_o    (word)
   );

   vs7_frame_ctl #(.SLICE(SLICE), .CLK_HIGH(CLK_HIGH), .SYNC_STAGES(SYNC_STAGES)) ctl_i (
      .clk_bit     (clk_bit),
      .rst_n       (pwr_n),
      .frame_start (frame_start),
      .pll_locked  (pll_locked),
      .load_o      (load),
      .en_o        (en),
      .pat_o       (clk_lane)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         vs7_lane_shift #(.SLICE(SLICE), .MSB_FIRST(MSB_FIRST)) sh_i (
            .clk     (clk_bit),
            .rst_n   (pwr_n),
            .load    (load),
            .slice_i (word[l*SLICE +: SLICE]),
            .ser_o   (ser[l])
         );
         assign lane_bit[l] = ser[l] & en;
      end
   endgenerate

   assign lanes_en = en;
endmodule

// File: rtl/vs7_serializer_chk.sv
`timescale 1ns/1ps
module vs7_serializer_chk #(
   parameter int unsigned LANES    = 4,
   parameter int unsigned SLICE    = 7,
   parameter int unsigned CLK_HIGH = 4
) (
   input logic             clk_bit,
   input logic             pwr_n,
   input logic             frame_start,
   input logic             lanes_en,
   input logic             clk_lane,
   input logic [LANES-1:0] lane_bit
);
   localparam int unsigned SW = $clog2(SLICE);

   logic [SW-1:0] slot_c;
   always_ff @(posedge clk_bit or negedge pwr_n) begin
      if (!pwr_n)                         slot_c <= SW'(SLICE - 1);
      else if (frame_start)               slot_c <= '0;
      else if (slot_c < SW'(SLICE - 1))   slot_c <= slot_c + 1'b1;
   end

   p_quiet_when_off_r7: assert property (@(posedge clk_bit) disable iff (!pwr_n)
      !lanes_en |-> (lane_bit == '0 && !clk_lane));

   p_en_on_frame_r7: assert property (@(posedge clk_bit) disable iff (!pwr_n)
      $rose(lanes_en) |-> $past(frame_start));

   p_clk_pattern_r4: assert property (@(posedge clk_bit) disable iff (!pwr_n)
      lanes_en |-> (clk_lane == (slot_c < SW'(CLK_HIGH))));

   p_cleared_after_pd_r6: assert property (@(posedge clk_bit) disable iff (!pwr_n)
      $rose(pwr_n) |-> (lane_bit == '0 && !clk_lane && !lanes_en));
endmodule

bind vs7_serializer vs7_serializer_chk #(.LANES(LANES), .SLICE(SLICE), .CLK_HIGH(CLK_HIGH)) chk_i (
   .clk_bit     (clk_bit),
   .pwr_n       (pwr_n),
   .frame_start (frame_start),
   .lanes_en    (lanes_en),
   .clk_lane    (clk_lane),
   .lane_bit    (lane_bit)
);

// File: tb/vs7_serializer_tb_top.sv
`timescale 1ns/1ps
module vs7_serializer_tb_top;
   // Bit clock 8 ns (125 MHz); pixel period 56 ns, rising at 2+56k, falling at 30+56k.
   // frame_start is sampled at the bit edge 44+56k; slot 0 is read at negedge 48+56k.
   logic        clk_bit = 1'b0;
   logic        clk_pix = 1'b0;
   logic        frame_start = 1'b0;
   logic        pll_locked = 1'b0;
   logic        edge_rise = 1'b1;
   logic        pwr_n = 1'b0;
   logic [27:0] pix_data = '0;
   logic [3:0]  lane_bit;
   logic        clk_lane;
   logic        lanes_en;

   int n_chk = 0;
   int n_fail = 0;
   logic [27:0] drv [int];

   vs7_serializer dut_i (
      .clk_pix(clk_pix), .clk_bit(clk_bit), .frame_start(frame_start),
      .pll_locked(pll_locked), .edge_rise(edge_rise), .pwr_n(pwr_n),
      .pix_data(pix_data), .lane_bit(lane_bit), .clk_lane(clk_lane), .lanes_en(lanes_en)
   );

   always #4 clk_bit = ~clk_bit;
   initial begin
      #2;
      forever begin clk_pix = 1'b1; #28; clk_pix = 1'b0; #28; end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Called at 46+56k: word a before the rising edge, word b before the falling edge.
   task automatic period(input logic [27:0] a, input logic [27:0] b);
      int k;
      k = int'(($time - 46) / 56);
      pix_data = a;
      if (pwr_n) drv[k] = edge_rise ? a : b;
      #26 pix_data = b;
      #30;
   endtask

   // Receiver model aligned on the clock lane
   longint      tnow, f_t;
   int          slot = 0;
   int          lock_low = 0;
   bit          in_frame = 1'b0;
   logic        prev_clk = 1'b0, prev_en = 1'b0;
   logic [27:0] acc;
   logic [6:0]  clk_acc, l0_seq;

   task automatic frame_done();
      int f;
      chk(clk_acc == 7'b1111000, "R4 clock lane pattern", 32'(clk_acc), 32'h78);
      chk((f_t / 8) % 7 == 6, "R5 slot 0 one bit cycle after frame mark", 32'(f_t), 32'(f_t));
      f = int'((f_t - 48) / 56);
      if (drv.exists(f - 1)) begin
         chk(acc == drv[f-1], "R1 R3 recovered word for selected edge", 32'(acc), 32'(drv[f-1]));
         if (drv[f-1] == 28'h40)
            chk(l0_seq == 7'b1000000, "R2 lane 0 bit 6 first", 32'(l0_seq), 32'h40);
         if (drv[f-1] == 28'h1)
            chk(l0_seq == 7'b0000001, "R2 lane 0 bit 0 last", 32'(l0_seq), 32'h1);
      end
   endtask

   always @(negedge clk_bit) begin
      tnow = $time;
      frame_start = ((tnow / 8) % 7 == 5);
      if (!pwr_n)
         chk(lane_bit == 4'h0 && !clk_lane && !lanes_en, "R6 outputs low in power-down",
             {26'h0, lanes_en, clk_lane, lane_bit}, 32'h0);
      if (pwr_n && !pll_locked) lock_low++; else lock_low = 0;
      if (lock_low == 4)
         chk(!lanes_en, "R7 enable drops after lock loss", 32'(lanes_en), 32'h0);
      if (lanes_en && !prev_en)
         chk((tnow / 8) % 7 == 6 && pll_locked, "R7 enable opens on frame boundary", 32'(tnow), 32'(tnow));
      if (!lanes_en) in_frame = 1'b0;
      else begin
         if (clk_lane && !prev_clk) begin
            in_frame = 1'b1; slot = 0; f_t = tnow; acc = '0; clk_acc = '0; l0_seq = '0;
         end
         if (in_frame) begin
            for (int l = 0; l < 4; l++) acc[l*7 + 6 - slot] = lane_bit[l];
            clk_acc[6 - slot] = clk_lane;
            l0_seq[6 - slot]  = lane_bit[0];
            slot++;
            if (slot == 7) begin
               in_frame = 1'b0;
               frame_done();
            end
         end
      end
      prev_clk = lanes_en ? clk_lane : 1'b0;
      prev_en  = lanes_en;
   end

   initial begin
      #500000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed1234));
      #20;
      chk(lane_bit == 4'h0 && !clk_lane && !lanes_en, "R6 reset state",
          {26'h0, lanes_en, clk_lane, lane_bit}, 32'h0);
      #26;
      pwr_n = 1'b1;
      period(28'h0, 28'h0);
      period(28'h0, 28'h0);
      pll_locked = 1'b1;
      period(28'h0, 28'h0);
      // directed ordering and mapping (R1, R2)
      edge_rise = 1'b1;
      period(28'h40, 28'h40);
      period(28'h1, 28'h1);
      period(28'hFFFFFFF, 28'h0);
      period(28'h0AAAAAA, 28'h5555555);
      for (int i = 0; i < 60; i++) period(28'($urandom), 28'($urandom));
      // falling-edge capture (R3)
      edge_rise = 1'b0;
      period(28'h0AAAAAA, 28'h5555555);
      period(28'h0, 28'hFFFFFFF);
      period(28'h40, 28'h40);
      for (int i = 0; i < 60; i++) period(28'($urandom), 28'($urandom));
      // power-down cycle (R6, R7)
      pwr_n = 1'b0; pll_locked = 1'b0;
      for (int i = 0; i < 4; i++) period(28'($urandom), 28'($urandom));
      pwr_n = 1'b1;
      period(28'h0, 28'h0);
      period(28'h0, 28'h0);
      pll_locked = 1'b1;
      for (int i = 0; i < 40; i++) begin
         edge_rise = 1'($urandom);
         period(28'($urandom), 28'($urandom));
      end
      // lock loss and recovery (R7)
      pll_locked = 1'b0;
      for (int i = 0; i < 3; i++) period(28'($urandom), 28'($urandom));
      pll_locked = 1'b1;
      for (int i = 0; i < 20; i++) begin
         edge_rise = 1'($urandom);
         period(28'($urandom), 28'($urandom));
      end
      period(28'h0, 28'h0);
      period(28'h0, 28'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule